// File: doc/BRIEF.md
# Flag-Setting Integer ALU

This block is the integer arithmetic stage of a small load-store RISC datapath. Each cycle it takes two 32-bit operands, an opcode and the current carry and overflow bits of the status register. One clock later it presents a 32-bit result and four condition flags: negative, zero, carry and overflow. It covers plain and carry-chained addition and subtraction, reverse subtraction, register moves (plain and inverted) and the two compare forms. The compare forms produce flags only.

The carry flag follows the inverted-borrow convention for every subtracting operation: carry is 1 when no borrow occurs. The carry-chained forms take the incoming carry, so wide arithmetic can be built one 32-bit word at a time. The block only computes flag values. A separate unit downstream decides whether the flags are committed. The `no_wb` output tells the register-write stage to discard the result.

Top module: `flagalu`

## Requirements
- R1: `flag_n` always equals bit 31 of `res`.
- R2: `flag_z` is 1 exactly when all 32 bits of `res` are zero.
- R3: Opcode 0 (add) gives A+B. Opcode 1 (add-with-carry) gives A+B+`c_in`. Opcode 8 (compare-negative) evaluates A+B. For all three, `flag_c` is the carry out of bit 31.
- R4: Opcode 2 (subtract) and opcode 7 (compare) evaluate A-B. Opcode 3 (subtract-with-carry) gives A+~B+`c_in`. Opcode 4 (reverse subtract) gives B-A. For all four, `flag_c` is 1 when the unsigned minuend is at least the subtrahend (plus the borrow for opcode 3), meaning no borrow occurred.
- R5: For opcodes 0–4, 7 and 8, `flag_v` is 1 exactly when the signed two's-complement result does not fit in 32 bits.
- R6: Opcodes 7 and 8 raise `no_wb`. Opcodes 0–6 keep it low. The flags of opcodes 7 and 8 come from the evaluated difference or sum.
- R7: Opcode 5 (move) gives `res` = B. Opcode 6 (move-inverted) gives `res` = ~B, the bitwise complement. For both, `flag_c` = `c_in` and `flag_v` = `v_in`.
- R8: Opcodes 9–15 are unused. For these, `res` = 0, `flag_n` = 0, `flag_z` = 1, `flag_c` = `c_in`, `flag_v` = `v_in` and `no_wb` = 1.
- R9: All outputs are registered and reflect the inputs sampled at the previous rising clock edge. A synchronous active-high `rst` clears every output to 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| op_a | input | 32 | Operand A |
| op_b | input | 32 | Operand B |
| opcode | input | 4 | Operation select (see R3–R8) |
| c_in | input | 1 | Incoming carry flag from the status register |
| v_in | input | 1 | Incoming overflow flag from the status register |
| res | output | 32 | Registered result |
| flag_n | output | 1 | Negative flag |
| flag_z | output | 1 | Zero flag |
| flag_c | output | 1 | Carry / not-borrow flag |
| flag_v | output | 1 | Signed overflow flag |
| no_wb | output | 1 | Result must not be written to a register |

## Verification
The assertions check on every cycle how the sign and zero flags relate to the registered result. They also check the plain-add carry and sum, the subtract not-borrow rule, and the move carry/overflow pass-through. They confirm that the compare opcodes always raise the discard indication.

The bench's scenarios cover the rest:
- signed overflow across the corner operands 0, 0x7FFFFFFF, 0x80000000 and 0xFFFFFFFF;
- carry-chained forms with both incoming carry values;
- reverse subtraction and the unused opcodes;
- the one-cycle latency and a reset applied in mid-run.

// File: rtl/flagalu_pkg.sv
package flagalu_pkg;
  localparam int OPW = 4;

  typedef enum logic [OPW-1:0] {
    OP_ADD = 4'd0,
    OP_ADC = 4'd1,
    OP_SUB = 4'd2,
    OP_SBC = 4'd3,
    OP_RSB = 4'd4,
    OP_MOV = 4'd5,
    OP_MVN = 4'd6,
    OP_CMP = 4'd7,
    OP_CMN = 4'd8
  } alu_op_e;

  typedef struct packed {
    logic n;
    logic z;
    logic c;
    logic v;
  } nzcv_t;
endpackage

// File: rtl/flagalu_opsel.sv
module flagalu_opsel
  import flagalu_pkg::*;
#(
  parameter int W = 32
) (
  input  logic [W-1:0]   a,
  input  logic [W-1:0]   b,
  input  logic [OPW-1:0] op,
  input  logic           c_in,
  output logic [W-1:0]   x,
  output logic [W-1:0]   y,
  output logic           ci,
  output logic           keep_cv,
  output logic           zero_res,
  output logic           discard
);
  always_comb begin
    x        = a;
    y        = b;
    ci       = 1'b0;
    keep_cv  = 1'b0;
    zero_res = 1'b0;
    discard  = 1'b0;
    case (op)
      OP_ADD: ;
      OP_ADC: ci = c_in;
      OP_SUB: begin y = ~b; ci = 1'b1; end
      OP_SBC: begin y = ~b; ci = c_in; end
      OP_RSB: begin x = b; y = ~a; ci = 1'b1; end
      OP_MOV: begin x = '0; keep_cv = 1'b1; end
      OP_MVN: begin x = '0; y = ~b; keep_cv = 1'b1; end
      OP_CMP: begin y = ~b; ci = 1'b1; discard = 1'b1; end
      OP_CMN: discard = 1'b1;
      default: begin
        x = '0; y = '0; keep_cv = 1'b1; zero_res = 1'b1; discard = 1'b1;
      end
    endcase
  end
endmodule

// File: rtl/flagalu_adder.sv
module flagalu_adder #(
  parameter int W = 32
) (
  input  logic [W-1:0] x,
  input  logic [W-1:0] y,
  input  logic         ci,
  output logic [W:0]   sum
);
  assign sum = {1'b0, x} + {1'b0, y} + {{W{1'b0}}, ci};
endmodule

// File: rtl/flagalu_flags.sv
module flagalu_flags
  import flagalu_pkg::*;
#(
  parameter int W = 32
) (
  input  logic [W:0]   sum,
  input  logic         x_msb,
  input  logic         y_msb,
  input  logic         keep_cv,
  input  logic         zero_res,
  input  logic         c_in,
  input  logic         v_in,
  output logic [W-1:0] res,
  output nzcv_t        fl
);
  localparam int MSB = W - 1;

  always_comb begin
    res  = zero_res ? '0 : sum[MSB:0];
    fl.n = res[MSB];
    fl.z = (res == '0);
    if (keep_cv) begin
      fl.c = c_in;
      fl.v = v_in;
    end else begin
      fl.c = sum[W];
      fl.v = (x_msb == y_msb) && (sum[MSB] != x_msb);
    end
  end
endmodule

// File: rtl/flagalu.sv
module flagalu
  import flagalu_pkg::*;
#(
  parameter int W = 32
) (
  input  logic           clk,
  input  logic           rst,
  input  logic [W-1:0]   op_a,
  input  logic [W-1:0]   op_b,
  input  logic [OPW-1:0] opcode,
  input  logic           c_in,
  input  logic           v_in,
  output logic [W-1:0]   res,
  output logic           flag_n,
  output logic           flag_z,
  output logic           flag_c,
  output logic           flag_v,
  output logic           no_wb
);
  localparam int MSB = W - 1;

  logic [W-1:0] x, y, res_d;
  logic         ci, keep_cv, zero_res, discard;
  logic [W:0]   sum;
  nzcv_t        fl_d;

  flagalu_opsel #(.W(W)) u_opsel (
    .a(op_a), .b(op_b), .op(opcode), .c_in(c_in),
    .x(x), .y(y), .ci(ci), .keep_cv(keep_cv),
    .zero_res(zero_res), .discard(discard)
  );

  flagalu_adder #(.W(W)) u_adder (.x(x), .y(y), .ci(ci), .sum(sum));

  flagalu_flags #(.W(W)) u_flags (
    .sum(sum), .x_msb(x[MSB]), .y_msb(y[MSB]), .keep_cv(keep_cv),
    .zero_res(zero_res), .c_in(c_in), .v_in(v_in), .res(res_d), .fl(fl_d)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      res    <= '0;
      flag_n <= 1'b0;
      flag_z <= 1'b0;
      flag_c <= 1'b0;
      flag_v <= 1'b0;
      no_wb  <= 1'b0;
    end else begin
      res    <= res_d;
      flag_n <= fl_d.n;
      flag_z <= fl_d.z;
      flag_c <= fl_d.c;
      flag_v <= fl_d.v;
      no_wb  <= discard;
    end
  end
endmodule

// File: rtl/flagalu_chk.sv
module flagalu_chk
  import flagalu_pkg::*;
#(
  parameter int W = 32
) (
  input logic           clk,
  input logic           rst,
  input logic [W-1:0]   op_a,
  input logic [W-1:0]   op_b,
  input logic [OPW-1:0] opcode,
  input logic           c_in,
  input logic           v_in,
  input logic [W-1:0]   res,
  input logic           flag_n,
  input logic           flag_z,
  input logic           flag_c,
  input logic           flag_v,
  input logic           no_wb
);
  AST_SIGN_FLAG: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> flag_n == res[W-1]); // R1
  AST_ZERO_FLAG: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> flag_z == (res == '0)); // R2
  AST_ADD_CARRY: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(opcode) == OP_ADD) |->
      {flag_c, res} == ({1'b0, $past(op_a)} + {1'b0, $past(op_b)})); // R3
  AST_SUB_NOBORROW: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(opcode) == OP_SUB) |->
      flag_c == ($past(op_a) >= $past(op_b))); // R4
  AST_CMP_DISCARD: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && ($past(opcode) == OP_CMP || $past(opcode) == OP_CMN)) |-> no_wb); // R6
  AST_MOVE_KEEPS_CV: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && ($past(opcode) == OP_MOV || $past(opcode) == OP_MVN)) |->
      (flag_c == $past(c_in) && flag_v == $past(v_in))); // R7
endmodule

bind flagalu flagalu_chk #(.W(W)) u_chk (.*);

// File: tb/sim_flagalu.sv
module sim_flagalu;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] op_a = '0, op_b = '0;
  logic [3:0]  opcode = '0;
  logic        c_in = 1'b0, v_in = 1'b0;
  logic [31:0] res;
  logic        flag_n, flag_z, flag_c, flag_v, no_wb;

  int tests = 0;
  int fails = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  flagalu u0 (.*);

  // returns {no_wb, n, z, c, v, res}
  function automatic logic [36:0] ref_calc(logic [3:0] op, logic [31:0] a, logic [31:0] b,
                                           logic ci, logic vi);
    longint sa = longint'($signed(a));
    longint sb = longint'($signed(b));
    longint s = 0;
    logic [63:0] u = '0;
    logic [31:0] r;
    logic c = ci, v = vi, nw = 1'b0, arith = 1'b1;
    case (op)
      4'd0, 4'd8: begin u = {32'b0, a} + {32'b0, b}; s = sa + sb; c = u[32]; end
      4'd1: begin u = {32'b0, a} + {32'b0, b} + {63'b0, ci}; s = sa + sb + longint'(ci); c = u[32]; end
      4'd2, 4'd7: begin s = sa - sb; c = (a >= b); end
      4'd3: begin s = sa - sb - 1 + longint'(ci); c = ({32'b0, a} + {63'b0, ci}) > {32'b0, b}; end
      4'd4: begin s = sb - sa; c = (b >= a); end
      4'd5: begin s = sb; arith = 1'b0; end
      4'd6: begin s = longint'($signed(~b)); arith = 1'b0; end
      default: begin s = 0; arith = 1'b0; end
    endcase
    r = s[31:0];
    if (arith) v = (s != longint'($signed(r)));
    if (op >= 4'd7) nw = 1'b1;
    return {nw, r[31], (r == 32'd0), c, v, r};
  endfunction

  function automatic string op_tag(logic [3:0] op);
    case (op)
      4'd0, 4'd1, 4'd8: return "R3";
      4'd2, 4'd3, 4'd4: return "R4";
      4'd7:             return "R6";
      4'd5, 4'd6:       return "R7";
      default:          return "R8";
    endcase
  endfunction

  task automatic chk(string tag, string what, logic [31:0] act, logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic run_one(logic [3:0] op, logic [31:0] a, logic [31:0] b, logic ci, logic vi);
    logic [36:0] e;
    string t;
    @(negedge clk);
    opcode = op; op_a = a; op_b = b; c_in = ci; v_in = vi;
    e = ref_calc(op, a, b, ci, vi);
    t = op_tag(op);
    @(negedge clk);
    chk(t, "res", res, e[31:0]);
    chk("R1", "N", {31'b0, flag_n}, {31'b0, e[35]});
    chk("R2", "Z", {31'b0, flag_z}, {31'b0, e[34]});
    chk(t, "C", {31'b0, flag_c}, {31'b0, e[33]});
    chk((op <= 4'd4 || op == 4'd7 || op == 4'd8) ? "R5" : t, "V",
        {31'b0, flag_v}, {31'b0, e[32]});
    chk((op == 4'd7 || op == 4'd8) ? "R6" : t, "no_wb", {31'b0, no_wb}, {31'b0, e[36]});
  endtask

  task automatic check_cleared();
    chk("R9", "reset res", res, 32'd0);
    chk("R9", "reset flags", {27'b0, flag_n, flag_z, flag_c, flag_v, no_wb}, 32'd0);
  endtask

  initial begin
    logic [31:0] corners [4];
    corners[0] = 32'h0000_0000; corners[1] = 32'h7FFF_FFFF;
    corners[2] = 32'h8000_0000; corners[3] = 32'hFFFF_FFFF;
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    check_cleared();
    rst = 1'b0;

    // R7/R8 directed
    run_one(4'd5, 32'h0, 32'h1234_5678, 1'b1, 1'b0);
    run_one(4'd6, 32'h0, 32'h0000_00FF, 1'b0, 1'b1);
    run_one(4'd9, 32'h5, 32'h6, 1'b1, 1'b1);
    run_one(4'd15, 32'hFFFF_FFFF, 32'h1, 1'b0, 1'b0);

    // R9 latency: new inputs not visible before the next rising edge
    @(negedge clk);
    opcode = 4'd0; op_a = 32'd1; op_b = 32'd1; c_in = 1'b0; v_in = 1'b0;
    #1 chk("R9", "latency hold", res, 32'd0);
    @(negedge clk);
    chk("R9", "latency update", res, 32'd2);

    // corner sweep
    for (int op = 0; op < 16; op++)
      for (int i = 0; i < 4; i++)
        for (int j = 0; j < 4; j++)
          for (int k = 0; k < 4; k++)
            run_one(op[3:0], corners[i], corners[j], k[0], k[1]);

    // R9 mid-run reset
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    check_cleared();
    rst = 1'b0;

    // random, biased towards small and edge operands
    for (int n = 0; n < 3000; n++) begin
      logic [31:0] ra, rb;
      ra = $urandom();
      rb = $urandom();
      if (n % 7 == 0) rb = ra;
      if (n % 11 == 0) ra = ra & 32'hF;
      run_one(4'($urandom_range(0, 15)), ra, rb, 1'($urandom()), 1'($urandom()));
    end

    if (!done) begin
      done = 1;
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      tests++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule